// File: doc/BRIEF.md
# Serial DAC Word Capture Front End

This block is the digital input side of a 16-bit serial-loaded converter. Four strobe pins, a serial data pin, two active-low load pins and an active-low clear pin arrive as asynchronous signals. A fast system clock samples them. Each accepted strobe edge shifts one data bit into a shift register, most significant bit first. A load then copies the shift register into the holding register whose value is the converter code.

The bit that leaves the top of the shift register is driven on a serial output. Several devices can therefore be chained on one three-wire bus, with each serial output feeding the next data input. A parameter sets the value that power-on reset and clear both produce: zero scale, or midscale with only the top bit set.

Top module: `sdac_front`

## Requirements
- R1: After `rst_n` is released, `code_o` is 0x0000 and `sdo_o` is 0 with `RESET_SCALE` = zero. With `RESET_SCALE` = midscale, `code_o` is 0x8000 and `sdo_o` is 1.
- R2: When 16 accepted strobe edges are followed by a load, `code_o` equals the 16 bits seen on `sdi_i` at those edges. The first bit becomes code bit 15.
- R3: The holding register copies the shift register when the combined condition (`load_a_n` low and `load_b_n` low) becomes true. If either pin is held low, the other pin alone controls the load.
- R4: While either load pin is high, `code_o` keeps its value, even while strobes shift data.
- R5: While `clr_n` is low, `code_o` and the shift register hold the reset value of R1 without waiting for a clock edge. Strobe edges and loads during clear have no effect. The next load after clear releases transfers the reset value.
- R6: Strobe bits 0, 1 and 3 are accepted on a low-to-high transition. Strobe bit 2 is accepted on a high-to-low transition. Their idle levels are low for bits 0, 1 and 3 and high for bit 2.
- R7: After each accepted edge, `sdo_o` shows the bit that was previously second from the top. A bit presented on `sdi_i` therefore reaches `sdo_o` after 16 accepted edges.
- R8: A strobe transition is ignored if any other strobe is away from its idle level at that sample. Two strobes that leave idle together cause no shift.
- R9: If a load and the final strobe edge are seen in the same cycle, the bit shifted on that edge is included in `code_o`.
- R10: Holding both load pins low loads once. Later shifts do not reach `code_o` until the combined condition goes false and then true again.
- R11: A change on a strobe, data or load pin affects `sdo_o` or `code_o` after the third rising clock edge that follows it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| strobe_i | input | NUM_STB (4) | Strobe pins; bit 2 is falling-edge active, the others rising-edge active |
| sdi_i | input | 1 | Serial data in, MSB first |
| load_a_n | input | 1 | First load pin, active low |
| load_b_n | input | 1 | Second load pin, active low |
| clr_n | input | 1 | Clear pin, active low, asynchronous |
| code_o | output | WORD_W (16) | Holding register value driven to the converter |
| sdo_o | output | 1 | Top bit of the shift register, for chaining |

## Verification
Pin changes pass through two synchroniser flops and then one register. The bench therefore drives on falling clock edges and expects strobe and load results on the third rising edge. It samples one falling edge after that, and the latency case checks both the second-edge and third-edge values. Clear acts at once, so it is checked 1 ns after the pin falls. After clear releases, the bench waits four cycles before it sends the next strobe. Every other result is sampled at least four cycles after its stimulus, and the next pin change comes only after that sample.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Value loaded by power-on reset and by clear
    typedef enum logic {
        SCALE_ZERO = 1'b0,
        SCALE_MID  = 1'b1
    } scale_e;

    // Decoded per-cycle events from the pin front end
    typedef struct packed {
        logic shift;
        logic load;
        logic data;
    } evt_t;

    // Transition into the active level while the rest of the strobes stay idle
    function automatic logic lone_rise(input logic cur, input logic prev, input logic others_busy);
        return cur & ~prev & ~others_busy;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d;
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
#(
    parameter int                 NUM_STB   = 4,
    parameter logic [NUM_STB-1:0] FALL_MASK = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STB-1:0] stb_s,
    input  logic               sdi_s,
    input  logic               lda_s,
    input  logic               ldb_s,
    output evt_t               evt,
    output logic [NUM_STB-1:0] hits
);

    typedef struct packed {
        logic [NUM_STB-1:0] stb;
        logic               ld;
    } edge_st_t;

    edge_st_t st_d, st_q;

    logic [NUM_STB-1:0] norm_cur;
    logic [NUM_STB-1:0] norm_prev;
    logic               ld_now;

    // Normalise so that every strobe idles at 0 and is accepted on 0 -> 1
    assign norm_cur  = stb_s ^ FALL_MASK;
    assign norm_prev = st_q.stb ^ FALL_MASK;
    assign ld_now    = ~lda_s & ~ldb_s;

    for (genvar g = 0; g < NUM_STB; g++) begin : g_strobe
        localparam logic [NUM_STB-1:0] SELF = NUM_STB'(1) << g;
        assign hits[g] = lone_rise(norm_cur[g], norm_prev[g], |(norm_cur & ~SELF));
    end

    always_comb begin
        st_d.stb  = stb_s;
        st_d.ld   = ld_now;
        evt.shift = |hits;
        evt.load  = ld_now & ~st_q.ld;
        evt.data  = sdi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stb <= FALL_MASK;
            st_q.ld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter logic [WORD_W-1:0] RST_WORD = '0
) (
    input  logic              clk,
    input  logic              arst_n,
    input  evt_t              evt,
    output logic [WORD_W-1:0] shreg,
    output logic [WORD_W-1:0] code,
    output logic              sdo
);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d.sh   = evt.shift ? {st_q.sh[WORD_W-2:0], evt.data} : st_q.sh;
        // A load in the same cycle as the last strobe edge takes the shifted word
        st_d.hold = evt.load ? st_d.sh : st_q.hold;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.sh   <= RST_WORD;
            st_q.hold <= RST_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg = st_q.sh;
    assign code  = st_q.hold;
    assign sdo   = st_q.sh[WORD_W-1];

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int                 WORD_W      = 16,
    parameter int                 NUM_STB     = 4,
    parameter logic [NUM_STB-1:0] FALL_MASK   = 4'b0100,
    parameter int                 SYNC_STAGES = 2,
    parameter scale_e             RESET_SCALE = SCALE_ZERO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STB-1:0] strobe_i,
    input  logic               sdi_i,
    input  logic               load_a_n,
    input  logic               load_b_n,
    input  logic               clr_n,
    output logic [WORD_W-1:0]  code_o,
    output logic               sdo_o
);

    localparam logic [WORD_W-1:0] MID_WORD = WORD_W'(1) << (WORD_W - 1);
    localparam logic [WORD_W-1:0] RST_WORD = (RESET_SCALE == SCALE_MID) ? MID_WORD : '0;

    logic [NUM_STB-1:0] stb_s;
    logic [2:0]         misc_s;
    logic               clr_arst_n;
    logic               clr_ok;
    evt_t               evt;
    logic               shift_w;
    logic               load_w;
    logic [NUM_STB-1:0] hits_w;
    logic [WORD_W-1:0]  shreg_w;

    sdac_sync #(
        .W       (NUM_STB),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (FALL_MASK)
    ) u_sync_stb (
        .clk    (clk),
        .arst_n (rst_n),
        .din    (strobe_i),
        .dout   (stb_s)
    );

    sdac_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync_misc (
        .clk    (clk),
        .arst_n (rst_n),
        .din    ({sdi_i, load_a_n, load_b_n}),
        .dout   (misc_s)
    );

    // Clear asserts at once and releases through the synchroniser chain
    assign clr_arst_n = rst_n & clr_n;

    sdac_sync #(
        .W       (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_sync_clr (
        .clk    (clk),
        .arst_n (clr_arst_n),
        .din    (1'b1),
        .dout   (clr_ok)
    );

    sdac_edge #(
        .NUM_STB   (NUM_STB),
        .FALL_MASK (FALL_MASK)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_s (stb_s),
        .sdi_s (misc_s[2]),
        .lda_s (misc_s[1]),
        .ldb_s (misc_s[0]),
        .evt   (evt),
        .hits  (hits_w)
    );

    sdac_regs #(
        .WORD_W   (WORD_W),
        .RST_WORD (RST_WORD)
    ) u_regs (
        .clk    (clk),
        .arst_n (clr_ok),
        .evt    (evt),
        .shreg  (shreg_w),
        .code   (code_o),
        .sdo    (sdo_o)
    );

    assign shift_w = evt.shift;
    assign load_w  = evt.load;

endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int                WORD_W   = 16,
    parameter int                NUM_STB  = 4,
    parameter logic [WORD_W-1:0] RST_WORD = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_n,
    input logic               reg_ok,
    input logic               shift_evt,
    input logic               load_evt,
    input logic [NUM_STB-1:0] hits,
    input logic [WORD_W-1:0]  shreg,
    input logic [WORD_W-1:0]  code_o,
    input logic               sdo_o
);

    AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code_o == RST_WORD && shreg == RST_WORD)); // R5

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ok && $past(reg_ok) && !$past(load_evt)) |-> $stable(code_o)); // R4

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ok && $past(reg_ok) && $past(load_evt) && !$past(shift_evt))
        |-> code_o == $past(shreg)); // R3

    AST_LOAD_MERGES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ok && $past(reg_ok) && $past(load_evt) && $past(shift_evt))
        |-> code_o[WORD_W-1:1] == $past(shreg[WORD_W-2:0])); // R9

    AST_SERIAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ok && $past(reg_ok) && $past(shift_evt))
        |-> sdo_o == $past(shreg[WORD_W-2])); // R7

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits)); // R8

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> !load_evt); // R10

endmodule

bind sdac_front sdac_front_chk #(
    .WORD_W   (WORD_W),
    .NUM_STB  (NUM_STB),
    .RST_WORD (RST_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .reg_ok    (clr_ok),
    .shift_evt (shift_w),
    .load_evt  (load_w),
    .hits      (hits_w),
    .shreg     (shreg_w),
    .code_o    (code_o),
    .sdo_o     (sdo_o)
);

// File: tb/tb_sdac_front.sv
module tb_sdac_front;
    import sdac_pkg::*;

    localparam int         W    = 16;
    localparam logic [3:0] IDLE = 4'b0100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b1;
    logic         sdi = 1'b0;
    logic         la = 1'b1;
    logic         lb = 1'b1;
    logic [3:0]   stb = IDLE;
    logic [W-1:0] code0, code1;
    logic         sdo0, sdo1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_sh [2];
    logic [W-1:0] m_hd [2];

    always #4 clk = ~clk;

    sdac_front dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(stb), .sdi_i(sdi),
        .load_a_n(la), .load_b_n(lb), .clr_n(clr_n),
        .code_o(code0), .sdo_o(sdo0)
    );

    sdac_front #(.RESET_SCALE(SCALE_MID)) dut_mid (
        .clk(clk), .rst_n(rst_n), .strobe_i(stb), .sdi_i(sdi),
        .load_a_n(la), .load_b_n(lb), .clr_n(clr_n),
        .code_o(code1), .sdo_o(sdo1)
    );

    function automatic logic [W-1:0] reset_val(input int k);
        return (k == 1) ? 16'h8000 : 16'h0000;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_code(input string req);
        check(req, "code zero-variant", code0, m_hd[0]);
        check(req, "code mid-variant", code1, m_hd[1]);
    endtask

    task automatic check_sdo(input string req);
        check(req, "sdo zero-variant", {15'd0, sdo0}, {15'd0, m_sh[0][W-1]});
        check(req, "sdo mid-variant", {15'd0, sdo1}, {15'd0, m_sh[1][W-1]});
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_sh[k] = reset_val(k);
            m_hd[k] = reset_val(k);
        end
    endtask

    task automatic model_shift(input logic b);
        for (int k = 0; k < 2; k++) m_sh[k] = {m_sh[k][W-2:0], b};
    endtask

    task automatic model_load();
        for (int k = 0; k < 2; k++) m_hd[k] = m_sh[k];
    endtask

    // One accepted strobe edge on strobe idx (R6 polarity per idle level)
    task automatic send_bit(input int idx, input logic b);
        sdi = b;
        tick(1);
        stb[idx] = ~IDLE[idx];
        tick(4);
        model_shift(b);
        check_sdo("R7");
        stb[idx] = IDLE[idx];
        tick(3);
    endtask

    task automatic send_word(input logic [W-1:0] w, input int idx);
        for (int i = W - 1; i >= 0; i--) begin
            send_bit((idx < 0) ? int'($urandom_range(3)) : idx, w[i]);
        end
    endtask

    // mode 0: both pins together; 1: b held low, a pulses; 2: a held low, b pulses
    task automatic do_load(input int mode);
        case (mode)
            0: begin
                la = 1'b0; lb = 1'b0; tick(4); model_load();
                check_code("R3");
                la = 1'b1; lb = 1'b1; tick(4);
            end
            1: begin
                lb = 1'b0; tick(4);
                check_code("R3");
                la = 1'b0; tick(4); model_load();
                check_code("R3");
                la = 1'b1; tick(4); lb = 1'b1; tick(4);
            end
            default: begin
                la = 1'b0; tick(4);
                check_code("R3");
                lb = 1'b0; tick(4); model_load();
                check_code("R3");
                lb = 1'b1; tick(4); la = 1'b1; tick(4);
            end
        endcase
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED0042));
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R1 reset values for both scale options
        check_code("R1");
        check_sdo("R1");

        // R2 / R6: each strobe alone, including the falling-edge one
        send_word(16'hA5C3, 2); do_load(0); check_code("R2 R6 falling strobe");
        send_word(16'h3C5A, 0); do_load(1); check_code("R2 R6 strobe0");
        send_word(16'h0F0F, 1); do_load(2); check_code("R2 R6 strobe1");
        send_word(16'hF00F, 3); do_load(0); check_code("R2 R6 strobe3");

        // R4: shifting with loads inactive leaves code alone
        for (int i = 0; i < 5; i++) send_bit(int'($urandom_range(3)), 1'($urandom_range(1)));
        check_code("R4");
        la = 1'b0; tick(4);
        send_bit(0, 1'b1);
        check_code("R4 one pin low");
        la = 1'b1; tick(4);

        // R10: holding both low loads once only
        la = 1'b0; lb = 1'b0; tick(4); model_load();
        check_code("R10 first load");
        send_word(16'($urandom), -1);
        check_code("R10 no reload");
        la = 1'b1; tick(4); la = 1'b0; tick(4); model_load();
        check_code("R10 new falling");
        la = 1'b1; lb = 1'b1; tick(4);

        // R9: load in the same cycle as the final strobe edge
        send_word(16'h1234, -1);
        for (int i = 14; i >= 0; i--) send_bit(0, 1'(16'hBEEF >> i));
        sdi = 1'b1; tick(1);
        stb[0] = 1'b1; la = 1'b0; lb = 1'b0;
        tick(4);
        model_shift(1'b1); model_load();
        check_code("R9");
        stb[0] = 1'b0; la = 1'b1; lb = 1'b1; tick(4);

        // R8: transitions with another strobe off idle are ignored
        sdi = 1'b1; tick(1);
        stb[1] = 1'b1; tick(4); model_shift(1'b1);
        stb[0] = 1'b1; tick(4);
        stb[1] = 1'b0; stb[0] = 1'b0; tick(4);
        stb[0] = 1'b1; stb[3] = 1'b1; tick(4);
        stb[2] = 1'b0; tick(4);
        stb = IDLE; tick(4);
        check_sdo("R8");
        do_load(0);
        check_code("R8");

        // R11: strobe latency to sdo
        send_word(16'hAAAA, 0);
        sdi = 1'b0; tick(1);
        stb[0] = 1'b1; tick(2);
        check_sdo("R11 before third edge");
        tick(1); model_shift(1'b0);
        check_sdo("R11 after third edge");
        stb[0] = 1'b0; tick(3);

        // R11: load latency to code
        la = 1'b0; lb = 1'b0; tick(2);
        check_code("R11 load before third edge");
        tick(1); model_load();
        check_code("R11 load after third edge");
        la = 1'b1; lb = 1'b1; tick(4);

        // R5: clear acts at once and masks strobes and loads
        for (int i = 0; i < 8; i++) send_bit(int'($urandom_range(3)), 1'($urandom_range(1)));
        clr_n = 1'b0; #1;
        model_reset();
        check_code("R5 immediate");
        check_sdo("R5 immediate");
        tick(1);
        sdi = 1'b1; stb[3] = 1'b1; tick(4); stb[3] = 1'b0; tick(4);
        la = 1'b0; lb = 1'b0; tick(4); la = 1'b1; lb = 1'b1; tick(4);
        check_code("R5 during clear");
        check_sdo("R5 during clear");
        clr_n = 1'b1; tick(4);
        check_code("R5 released");
        do_load(0);
        check_code("R5 cleared shift register");

        // Random words with random strobes and load styles
        for (int n = 0; n < 30; n++) begin
            send_word(16'($urandom), -1);
            do_load(int'($urandom_range(2)));
            check_code("R2 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule